// File: doc/BRIEF.md
# Variable refresh vertical timing controller

This block produces the vertical scanline count for a display timing pipeline. It advances one line per line tick. It raises a vertical blanking flag and pulses a strobe that tells shadowed configuration registers to latch. In fixed mode the frame has a programmed total, and the latch strobe fires when blanking begins.

In variable mode the frame length is not fixed. Blanking is held open until software posts a push request, or until a programmed decision line is reached. At that point the exit phase begins. It lasts a guardband number of lines and then a new frame starts.

A push is honoured only inside a window. The earliest trigger line comes from the minimum frame length, taken from the flipline value or from vmin. The latest trigger line is the maximum total less the guardband. A change to the mode enable takes effect at the next frame start, and a live flag reports the mode that is actually running.

Top module: `vrr_vtiming`

## Requirements
- R1: While reset is held, line_o is 0, and vblank_o, frame_start_o, latch_o, push_busy_o and live_o are all 0.
- R2: With live_o low, a frame is vtotal_i+1 lines long. vblank_o is high for lines at or above vblank_start_i. latch_o pulses once per frame, in the cycle where line_o first equals vblank_start_i. frame_start_o pulses in each cycle where line_o has just wrapped to 0.
- R3: line_o changes only on cycles where line_en_i is high. With line_en_i low, line_o holds and frame_start_o stays low.
- R4: With live_o high and no push, every frame is vmax_i+1 lines. vmin_i, vmax_i and flipline_i each hold a line count minus one.
- R5: With live_o high, a push written while line_o = P triggers the exit on the tick of line T = max(P+1, E), provided T <= D. Here D = vmax_i - guardband_i. The frame is then T + guardband_i + 1 lines, and latch_o pulses in the cycle where line_o = T+1 (or 0 on wrap).
- R6: E = flipline_i - guardband_i when flipline_en_i is 1, and E = vmin_i + 1 - guardband_i when it is 0.
- R7: With vmin_i = vmax_i = flipline_i, every frame is vmax_i+1 lines, whether or not a push arrives.
- R8: A push write with push_en_i=1 and push_send_i=1 sets push_busy_o. A push write with either bit 0 clears it. push_busy_o clears on the tick where a pending push triggers the exit. A write in that same cycle takes priority and leaves it set.
- R9: A push write while vrr_en_i is 0 leaves push_busy_o at 0.
- R10: A change of vrr_en_i mid-frame changes live_o only in the cycle where frame_start_o is high. The current frame keeps its mode.
- R11: A push written after the exit has triggered stays pending and shortens the next frame.
- R12: With guardband_i = 0, a push-triggered exit wraps the frame on the trigger tick, so latch_o and frame_start_o are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_en_i | input | 1 | One-cycle line tick |
| vtotal_i | input | LINE_W | Fixed-mode total lines minus one |
| vblank_start_i | input | LINE_W | First blanking line |
| vmin_i | input | LINE_W | Minimum total minus one |
| vmax_i | input | LINE_W | Maximum total minus one |
| flipline_i | input | LINE_W | Minimum generated total minus one |
| guardband_i | input | LINE_W | Exit length in lines |
| vrr_en_i | input | 1 | Variable mode enable |
| flipline_en_i | input | 1 | Use flipline_i for the early bound |
| push_wr_i | input | 1 | Push register write strobe |
| push_en_i | input | 1 | Push enable bit of the write |
| push_send_i | input | 1 | Push send bit of the write |
| line_o | output | LINE_W | Current line |
| vblank_o | output | 1 | Vertical blanking |
| frame_start_o | output | 1 | Frame start pulse |
| latch_o | output | 1 | Register latch strobe |
| push_busy_o | output | 1 | Send bit readback |
| live_o | output | 1 | Variable mode running |

## Verification
Two events can land on the same clock edge: a new push write and the hardware consuming the pending push. The bench provokes this by issuing a second write on the exact line where the first push triggers the exit. It then judges the outcome by push_busy_o staying set and by the next frame being short.

A second pair can also coincide: with a zero guardband, the latch strobe and the frame start fall on the same edge. This case is judged by both pulses being high in the one sampled cycle at line 0.

// File: rtl/vrr_vt_pkg.sv
package vrr_vt_pkg;
  typedef enum logic {
    PH_ACTIVE = 1'b0,
    PH_EXIT   = 1'b1
  } vrr_phase_e;
endpackage

// File: rtl/vrr_window.sv
module vrr_window #(
  parameter int unsigned LINE_W = 12
) (
  input  logic [LINE_W-1:0] vmin_i,
  input  logic [LINE_W-1:0] vmax_i,
  input  logic [LINE_W-1:0] flipline_i,
  input  logic [LINE_W-1:0] guardband_i,
  input  logic              flipline_en_i,
  output logic [LINE_W-1:0] early_o,
  output logic [LINE_W-1:0] late_o
);
  logic [LINE_W-1:0] base;

  always_comb begin
    base    = flipline_en_i ? flipline_i : vmin_i + 1'b1;
    early_o = (base > guardband_i) ? base - guardband_i : '0;
    late_o  = (vmax_i > guardband_i) ? vmax_i - guardband_i : '0;
  end
endmodule

// File: rtl/vrr_push_ctl.sv
module vrr_push_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic en_i,
  input  logic send_i,
  input  logic vrr_en_i,
  input  logic consume_i,
  input  logic drop_i,
  output logic pending_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pending_o <= 1'b0;
    else if (wr_i)              pending_o <= vrr_en_i & en_i & send_i;
    else if (consume_i | drop_i) pending_o <= 1'b0;
  end
endmodule

// File: rtl/vrr_line_ctr.sv
module vrr_line_ctr
  import vrr_vt_pkg::*;
#(
  parameter int unsigned LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_en_i,
  input  logic [LINE_W-1:0] vtotal_i,
  input  logic [LINE_W-1:0] vblank_start_i,
  input  logic [LINE_W-1:0] vmax_i,
  input  logic [LINE_W-1:0] guardband_i,
  input  logic [LINE_W-1:0] early_i,
  input  logic [LINE_W-1:0] late_i,
  input  logic              vrr_en_i,
  input  logic              pending_i,
  output logic              consume_o,
  output logic              drop_o,
  output logic [LINE_W-1:0] line_o,
  output logic              vblank_o,
  output logic              frame_start_o,
  output logic              latch_o,
  output logic              live_o
);
  logic [LINE_W-1:0] line_q, line_d, end_q, exit_end;
  vrr_phase_e        phase_q;
  logic              live_q, fs_q, latch_q;
  logic              trig, wrap, latch_fix, in_exit;

  always_comb begin
    in_exit  = (phase_q == PH_EXIT);
    trig     = line_en_i && live_q && !in_exit &&
               ((pending_i && (line_q >= early_i)) || (line_q >= late_i));
    exit_end = in_exit ? end_q : line_q + guardband_i;
    if (live_q)
      wrap = line_en_i && ((((in_exit || trig) && (line_q >= exit_end))) ||
                           (line_q >= vmax_i));
    else
      wrap = line_en_i && (line_q >= vtotal_i);
    line_d    = wrap ? '0 : line_q + 1'b1;
    latch_fix = line_en_i && !live_q && (line_d == vblank_start_i);
  end

  assign consume_o = trig && pending_i;
  assign drop_o    = wrap && !vrr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      end_q   <= '0;
      phase_q <= PH_ACTIVE;
      live_q  <= 1'b0;
      fs_q    <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      fs_q    <= wrap;
      latch_q <= trig | latch_fix;
      if (line_en_i) line_q <= line_d;
      if (wrap) begin
        phase_q <= PH_ACTIVE;
        live_q  <= vrr_en_i;
      end else if (trig) begin
        phase_q <= PH_EXIT;
        end_q   <= line_q + guardband_i;
      end
    end
  end

  assign line_o        = line_q;
  assign vblank_o      = (line_q >= vblank_start_i);
  assign frame_start_o = fs_q;
  assign latch_o       = latch_q;
  assign live_o        = live_q;
endmodule

// File: rtl/vrr_vtiming.sv
module vrr_vtiming #(
  parameter int unsigned LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_en_i,
  input  logic [LINE_W-1:0] vtotal_i,
  input  logic [LINE_W-1:0] vblank_start_i,
  input  logic [LINE_W-1:0] vmin_i,
  input  logic [LINE_W-1:0] vmax_i,
  input  logic [LINE_W-1:0] flipline_i,
  input  logic [LINE_W-1:0] guardband_i,
  input  logic              vrr_en_i,
  input  logic              flipline_en_i,
  input  logic              push_wr_i,
  input  logic              push_en_i,
  input  logic              push_send_i,
  output logic [LINE_W-1:0] line_o,
  output logic              vblank_o,
  output logic              frame_start_o,
  output logic              latch_o,
  output logic              push_busy_o,
  output logic              live_o
);
  logic [LINE_W-1:0] early, late;
  logic              pending, consume, drop;

  vrr_window #(.LINE_W(LINE_W)) u_window (
    .vmin_i        (vmin_i),
    .vmax_i        (vmax_i),
    .flipline_i    (flipline_i),
    .guardband_i   (guardband_i),
    .flipline_en_i (flipline_en_i),
    .early_o       (early),
    .late_o        (late)
  );

  vrr_push_ctl u_push (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (push_wr_i),
    .en_i      (push_en_i),
    .send_i    (push_send_i),
    .vrr_en_i  (vrr_en_i),
    .consume_i (consume),
    .drop_i    (drop),
    .pending_o (pending)
  );

  vrr_line_ctr #(.LINE_W(LINE_W)) u_ctr (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .line_en_i      (line_en_i),
    .vtotal_i       (vtotal_i),
    .vblank_start_i (vblank_start_i),
    .vmax_i         (vmax_i),
    .guardband_i    (guardband_i),
    .early_i        (early),
    .late_i         (late),
    .vrr_en_i       (vrr_en_i),
    .pending_i      (pending),
    .consume_o      (consume),
    .drop_o         (drop),
    .line_o         (line_o),
    .vblank_o       (vblank_o),
    .frame_start_o  (frame_start_o),
    .latch_o        (latch_o),
    .live_o         (live_o)
  );

  assign push_busy_o = pending;
endmodule

// File: rtl/vrr_vtiming_chk.sv
module vrr_vtiming_chk #(
  parameter int unsigned LINE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_en_i,
  input logic              vrr_en_i,
  input logic              push_wr_i,
  input logic              push_en_i,
  input logic              push_send_i,
  input logic [LINE_W-1:0] line_o,
  input logic              frame_start_o,
  input logic              push_busy_o,
  input logic              live_o
);
  // R2
  fs_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (line_o == '0));
  // R3
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_en_i |=> ($stable(line_o) && !frame_start_o));
  // R8
  push_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_wr_i && push_en_i && push_send_i && vrr_en_i) |=> push_busy_o);
  // R8
  push_no_spont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_wr_i && !push_busy_o) |=> !push_busy_o);
  // R9
  push_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_wr_i && !vrr_en_i) |=> !push_busy_o);
  // R10
  live_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_o |-> $stable(live_o));
endmodule

bind vrr_vtiming vrr_vtiming_chk #(.LINE_W(LINE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .line_en_i     (line_en_i),
  .vrr_en_i      (vrr_en_i),
  .push_wr_i     (push_wr_i),
  .push_en_i     (push_en_i),
  .push_send_i   (push_send_i),
  .line_o        (line_o),
  .frame_start_o (frame_start_o),
  .push_busy_o   (push_busy_o),
  .live_o        (live_o)
);

// File: tb/vrr_vtiming_tb.sv
`timescale 1ns/1ps
module vrr_vtiming_tb;
  localparam int W = 12;
  localparam int NONE = 999;
  // vmin, vmax, flip, gb, flip_en, push_line, expected length
  localparam int VEC [8][7] = '{
    '{19, 39, 20, 4, 1, NONE, 40},
    '{19, 39, 20, 4, 1, 5,    21},
    '{19, 39, 20, 4, 1, 25,   31},
    '{19, 39, 20, 4, 1, 34,   40},
    '{29, 29, 29, 3, 1, NONE, 30},
    '{29, 29, 29, 3, 1, 2,    30},
    '{19, 39, 30, 4, 0, 5,    21},
    '{19, 39, 30, 4, 1, 5,    31}
  };

  logic clk = 0, rst_ni = 0, line_en = 1;
  logic [W-1:0] vtotal = 24, vbs = 15, vmin = 19, vmax = 39, flip = 20, gb = 4;
  logic vrr_en = 0, flip_en = 1, push_wr = 0, push_en = 0, push_send = 0;
  logic [W-1:0] line_o;
  logic vblank_o, frame_start_o, latch_o, push_busy_o, live_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  vrr_vtiming #(.LINE_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .line_en_i(line_en),
    .vtotal_i(vtotal), .vblank_start_i(vbs), .vmin_i(vmin), .vmax_i(vmax),
    .flipline_i(flip), .guardband_i(gb), .vrr_en_i(vrr_en),
    .flipline_en_i(flip_en), .push_wr_i(push_wr), .push_en_i(push_en),
    .push_send_i(push_send), .line_o(line_o), .vblank_o(vblank_o),
    .frame_start_o(frame_start_o), .latch_o(latch_o),
    .push_busy_o(push_busy_o), .live_o(live_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start_o);
  endtask

  task automatic wait_line(input int l);
    do @(negedge clk); while (line_o != l[W-1:0]);
  endtask

  // Starts at a frame-start sample; counts lines until the next one.
  task automatic run_frame(input int pa, input int pb, input bit sb,
                           output int len, output int lat_line, output bit lat_end);
    len = 0; lat_line = -1; lat_end = 0;
    for (int k = 0; k < 4000; k++) begin
      if (line_o == pa[W-1:0]) begin
        push_wr = 1; push_en = 1; push_send = 1;
      end else if (line_o == pb[W-1:0]) begin
        push_wr = 1; push_en = 1; push_send = sb;
      end
      @(negedge clk);
      push_wr = 0;
      len++;
      if (latch_o) lat_line = line_o;
      if (frame_start_o) begin
        lat_end = latch_o;
        break;
      end
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len, ll, prev;
    bit le;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(line_o == 0, "R1 line", line_o, 0);
    chk(!vblank_o && !frame_start_o && !latch_o, "R1 flags",
        {vblank_o, frame_start_o, latch_o}, 0);
    chk(!push_busy_o && !live_o, "R1 busy/live", {push_busy_o, live_o}, 0);
    rst_ni = 1;

    // R3 stall
    repeat (4) @(negedge clk);
    line_en = 0; prev = line_o;
    repeat (5) @(negedge clk);
    chk(line_o == prev, "R3 hold", line_o, prev);
    line_en = 1;
    @(negedge clk);
    chk(line_o == prev + 1, "R3 resume", line_o, prev + 1);

    // R2 fixed mode
    wait_fs();
    chk(!vblank_o, "R2 vblank low at 0", vblank_o, 0);
    run_frame(NONE, NONE, 1, len, ll, le);
    chk(len == 25, "R2 length", len, 25);
    chk(ll == 15, "R2 latch line", ll, 15);
    wait_line(15);
    chk(vblank_o, "R2 vblank high", vblank_o, 1);

    // R9 push ignored while disabled
    wait_line(3);
    push_wr = 1; push_en = 1; push_send = 1;
    @(negedge clk);
    push_wr = 0;
    chk(!push_busy_o, "R9 busy", push_busy_o, 0);
    wait_fs();
    run_frame(NONE, NONE, 1, len, ll, le);
    chk(len == 25, "R9 length", len, 25);

    // R10 enable mid-frame
    wait_line(10);
    vrr_en = 1;
    @(negedge clk);
    chk(!live_o, "R10 live before boundary", live_o, 0);
    wait_fs();
    chk(live_o, "R10 live at boundary", live_o, 1);
    run_frame(NONE, NONE, 1, len, ll, le);
    chk(len == 40, "R10 first variable frame", len, 40);

    // Table walk: R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      vmin = VEC[v][0][W-1:0]; vmax = VEC[v][1][W-1:0];
      flip = VEC[v][2][W-1:0]; gb = VEC[v][3][W-1:0];
      flip_en = VEC[v][4][0];
      wait_fs();
      run_frame(NONE, NONE, 1, len, ll, le);
      run_frame(VEC[v][5], NONE, 1, len, ll, le);
      chk(len == VEC[v][6], $sformatf("R4/R5/R6/R7 vector %0d length", v), len, VEC[v][6]);
      chk(ll == VEC[v][6] - VEC[v][3], $sformatf("R5 vector %0d latch line", v),
          ll, VEC[v][6] - VEC[v][3]);
      chk(!push_busy_o, $sformatf("R8 vector %0d consumed", v), push_busy_o, 0);
    end

    vmin = 19; vmax = 39; flip = 20; gb = 4; flip_en = 1;
    wait_fs();
    run_frame(NONE, NONE, 1, len, ll, le);

    // R11 push after trigger carries over
    run_frame(36, NONE, 1, len, ll, le);
    chk(len == 40, "R11 late push frame", len, 40);
    chk(push_busy_o, "R11 still pending", push_busy_o, 1);
    run_frame(NONE, NONE, 1, len, ll, le);
    chk(len == 21, "R11 next frame short", len, 21);

    // R8 write with send=0 clears
    run_frame(2, 5, 0, len, ll, le);
    chk(len == 40, "R8 cleared push", len, 40);

    // R8 write coinciding with consumption wins
    run_frame(5, 16, 1, len, ll, le);
    chk(len == 21, "R8 coincide frame", len, 21);
    chk(push_busy_o, "R8 coincide pending", push_busy_o, 1);
    run_frame(NONE, NONE, 1, len, ll, le);
    chk(len == 21, "R8 coincide next frame", len, 21);
    chk(!push_busy_o, "R8 coincide consumed", push_busy_o, 0);

    // R12 zero guardband
    gb = 0;
    wait_fs();
    run_frame(NONE, NONE, 1, len, ll, le);
    run_frame(25, NONE, 1, len, ll, le);
    chk(len == 27, "R12 length", len, 27);
    chk(le, "R12 latch with frame start", le, 1);
    gb = 4;

    // R10 disable mid-frame
    wait_fs();
    run_frame(NONE, NONE, 1, len, ll, le);
    len = 0;
    for (int k = 0; k < 4000; k++) begin
      if (line_o == 10) vrr_en = 0;
      @(negedge clk);
      len++;
      if (frame_start_o) break;
      if (line_o == 20) chk(live_o, "R10 live holds", live_o, 1);
    end
    chk(len == 40, "R10 frame keeps mode", len, 40);
    chk(!live_o, "R10 live drops at boundary", live_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule